// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block lets one board raise an interrupt on a shared backplane that carries seven active-low request lines, numbered 1 to 7. A local request pulse marks the requester pending. While pending, the block pulls low the one line chosen by its configured level. When the interrupt handler starts an acknowledge cycle, it puts a level number on the low address lines and pulls both strobes low. An acknowledge token then travels down a daisy chain of requesters. A requester that holds the token and is pending on the acknowledged level takes the cycle: it drives a programmable 8-bit status byte, releases its request line and pulls the transfer acknowledge low. Any other requester hands the token on through its chain output.

Several boards can share one request line. The board nearest the head of the chain is served first. A board further down keeps its line low until a later acknowledge cycle reaches it. The chain input and both strobes pass through a parameterised synchronizer before the decision logic samples them. The level lines are sampled directly, because they settle before the strobes fall.

Top module: `irqc_daisy_interrupter`

## Requirements
- R1: After reset all request lines are high, the chain output and the transfer acknowledge are high, and the data-enable output is low with zero data.
- R2: A one-cycle pulse on the local request makes the block pending. While pending with configured level L (1 to 7), bit L-1 of the request-line vector is low and every other bit is high. Level 0 drives no line.
- R3: An acknowledge cycle is both strobes low plus the chain input low. If the block is pending, its level is nonzero and the address level equals it, the block drives the status byte with data-enable high and pulls the transfer acknowledge low within SYNC_STAGES+2 cycles. Its request line goes high in the same cycle.
- R4: In an acknowledge cycle where the block is not pending, or the address level differs from its level, the block pulls the chain output low, keeps the transfer acknowledge high and the data-enable low, and stays pending.
- R5: The chain output goes low only after the synchronized chain input was seen low. It returns high within SYNC_STAGES+2 cycles after the chain input goes high.
- R6: Once both strobes are high again, the transfer acknowledge returns high and the data-enable goes low within SYNC_STAGES+2 cycles. Neither is released while the data strobe stays low.
- R7: The pending state is cleared only by delivering the status byte. A second acknowledge cycle on the same level after a delivery is passed down the chain.
- R8: When two chained blocks are pending on the same level, the first acknowledge cycle is served by the upstream block. The downstream block sees no chain input, keeps its line low, and is served by the next acknowledge cycle.
- R9: The status byte is the value last written through the byte-write strobe before the acknowledge cycle. A later write replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_cfg | input | 3 | Request level, 1 to 7; 0 disables |
| sid_we | input | 1 | Status byte write strobe |
| sid_wdata | input | 8 | Status byte write value |
| src_req | input | 1 | Local request pulse |
| irq_line_n | output | 7 | Active-low request lines, bit k is level k+1 |
| addr_lvl | input | 3 | Level number from the handler's address lines |
| strobe_as_n | input | 1 | Address strobe, active low |
| strobe_ds_n | input | 1 | Data strobe, active low |
| ack_chain_in_n | input | 1 | Acknowledge token from upstream, active low |
| ack_chain_out_n | output | 1 | Acknowledge token to downstream, active low |
| xfer_ack_n | output | 1 | Transfer acknowledge, active low |
| vec_data | output | 8 | Status byte, zero when not driven |
| vec_oe | output | 1 | Data bus enable for the status byte |

## Verification
A lost or stuck pending flag shows on the request lines at once, and it shows again at the next acknowledge cycle as a pass where a response was due, or the reverse. A controller state that is wrong shows within SYNC_STAGES+2 cycles of a strobe or chain edge. Either the transfer acknowledge or the chain output fails to move, or both move together. Two chained instances sharing one level expose an ordering fault through which instance's byte appears first and whether the downstream line stays low between cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_SERVE = 2'd1,
      CH_PASS  = 2'd2
   } chain_st_e;

   // bit positions inside the synchronised strobe bundle
   localparam int SB_AS  = 0;
   localparam int SB_DS  = 1;
   localparam int SB_ACK = 2;
   localparam int SB_W   = 3;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_raw,
   output logic [WIDTH-1:0] d_sync
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("irqc_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign d_sync = d_raw;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pipe_q[s] <= '1;
               end else if (s == 0) begin
                  pipe_q[s] <= d_raw;
               end else begin
                  pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign d_sync = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
   parameter int NUM_LINES = 7,
   parameter int LVL_W     = 3,
   parameter int ID_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LVL_W-1:0]     line_cfg,
   input  logic                 sid_we,
   input  logic [ID_W-1:0]      sid_wdata,
   input  logic                 src_req,
   input  logic                 deliver,
   output logic                 pend,
   output logic [ID_W-1:0]      sid_q,
   output logic [NUM_LINES-1:0] irq_line_n
);

   logic pend_q;

   // a fresh request in the delivery cycle wins: it is a new event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (src_req) begin
         pend_q <= 1'b1;
      end else if (deliver) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sid_q <= '0;
      end else if (sid_we) begin
         sid_q <= sid_wdata;
      end
   end

   assign pend = pend_q;

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
         assign irq_line_n[k] = ~(pend_q && (line_cfg == LVL_W'(k + 1)));
      end
   endgenerate

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !deliver) |=> pend_q); // R7

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~irq_line_n) <= 1); // R2

endmodule

// File: rtl/irqc_chain_fsm.sv
module irqc_chain_fsm
   import irqc_pkg::*;
#(
   parameter int NUM_LINES = 7,
   parameter int LVL_W     = 3,
   parameter int ID_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SB_W-1:0]   strb_q,
   input  logic [LVL_W-1:0]  addr_lvl,
   input  logic [LVL_W-1:0]  line_cfg,
   input  logic              pend,
   input  logic [ID_W-1:0]   sid_q,
   output logic              deliver,
   output logic              ack_chain_out_n,
   output logic              xfer_ack_n,
   output logic [ID_W-1:0]   vec_data,
   output logic              vec_oe
);

   chain_st_e st_q, st_nxt;
   logic [ID_W-1:0] vec_q;
   logic as_q, ds_q, ack_q;
   logic lvl_ok, hit, cyc_open, strobes_gone;

   assign as_q  = strb_q[SB_AS];
   assign ds_q  = strb_q[SB_DS];
   assign ack_q = strb_q[SB_ACK];

   assign lvl_ok       = (line_cfg != '0) && (line_cfg <= LVL_W'(NUM_LINES));
   assign hit          = pend && lvl_ok && (addr_lvl == line_cfg);
   assign cyc_open     = !as_q && !ds_q && !ack_q;
   assign strobes_gone = as_q && ds_q;

   always_comb begin
      st_nxt  = st_q;
      deliver = 1'b0;
      unique case (st_q)
         CH_IDLE: begin
            if (cyc_open) begin
               if (hit) begin
                  st_nxt  = CH_SERVE;
                  deliver = 1'b1;
               end else begin
                  st_nxt = CH_PASS;
               end
            end
         end
         CH_SERVE: begin
            if (strobes_gone) st_nxt = CH_IDLE;
         end
         CH_PASS: begin
            if (ack_q) st_nxt = CH_IDLE;
         end
         default: st_nxt = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= CH_IDLE;
      end else begin
         st_q <= st_nxt;
      end
   end

   // byte is frozen at delivery so a late rewrite cannot tear the transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
      end else if (deliver) begin
         vec_q <= sid_q;
      end else if (st_nxt != CH_SERVE) begin
         vec_q <= '0;
      end
   end

   assign ack_chain_out_n = (st_q != CH_PASS);
   assign xfer_ack_n      = (st_q != CH_SERVE);
   assign vec_oe          = (st_q == CH_SERVE);
   assign vec_data        = vec_q;

   AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_chain_out_n) |-> $past(!ack_q)); // R5

   AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_chain_out_n && ack_q) |=> ack_chain_out_n); // R5

   AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_ack_n && !ds_q) |=> !xfer_ack_n); // R6

   AST_SERVE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_ack_n) |-> $past(pend)); // R3

endmodule

// File: rtl/irqc_daisy_interrupter.sv
module irqc_daisy_interrupter
   import irqc_pkg::*;
#(
   parameter  int NUM_LINES   = 7,
   parameter  int ID_W        = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int LVL_W       = $clog2(NUM_LINES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LVL_W-1:0]     line_cfg,
   input  logic                 sid_we,
   input  logic [ID_W-1:0]      sid_wdata,
   input  logic                 src_req,
   output logic [NUM_LINES-1:0] irq_line_n,
   input  logic [LVL_W-1:0]     addr_lvl,
   input  logic                 strobe_as_n,
   input  logic                 strobe_ds_n,
   input  logic                 ack_chain_in_n,
   output logic                 ack_chain_out_n,
   output logic                 xfer_ack_n,
   output logic [ID_W-1:0]      vec_data,
   output logic                 vec_oe
);

   generate
      if (NUM_LINES < 1 || NUM_LINES > 7) begin : g_bad_lines
         $error("irqc_daisy_interrupter: NUM_LINES must be 1..7");
      end
      if (ID_W < 1 || ID_W > 32) begin : g_bad_id
         $error("irqc_daisy_interrupter: ID_W must be 1..32");
      end
   endgenerate

   logic [SB_W-1:0] strb_raw, strb_q;
   logic            pend, deliver;
   logic [ID_W-1:0] sid_q;

   always_comb begin
      strb_raw         = '1;
      strb_raw[SB_AS]  = strobe_as_n;
      strb_raw[SB_DS]  = strobe_ds_n;
      strb_raw[SB_ACK] = ack_chain_in_n;
   end

   irqc_sync #(.STAGES(SYNC_STAGES), .WIDTH(SB_W)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_raw  (strb_raw),
      .d_sync (strb_q)
   );

   irqc_pending #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .ID_W(ID_W)) pend_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_cfg   (line_cfg),
      .sid_we     (sid_we),
      .sid_wdata  (sid_wdata),
      .src_req    (src_req),
      .deliver    (deliver),
      .pend       (pend),
      .sid_q      (sid_q),
      .irq_line_n (irq_line_n)
   );

   irqc_chain_fsm #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .ID_W(ID_W)) fsm_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .strb_q          (strb_q),
      .addr_lvl        (addr_lvl),
      .line_cfg        (line_cfg),
      .pend            (pend),
      .sid_q           (sid_q),
      .deliver         (deliver),
      .ack_chain_out_n (ack_chain_out_n),
      .xfer_ack_n      (xfer_ack_n),
      .vec_data        (vec_data),
      .vec_oe          (vec_oe)
   );

   AST_SERVE_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_ack_n |-> (&irq_line_n || src_req || $past(src_req))); // R3

   AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_oe |-> (vec_data == '0)); // R6

   AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!xfer_ack_n && !ack_chain_out_n)); // R4

endmodule

// File: tb/irqc_daisy_interrupter_tb.sv
module irqc_daisy_interrupter_tb_top;

   localparam int NL = 7;
   localparam int IW = 8;
   localparam int SS = 2;
   localparam int WAITMAX = SS + 6;

   // [15:13] level cfg, [12] request, [11:9] ack level, [8] expect serve, [7:0] byte
   localparam logic [15:0] VEC [0:7] = '{
      16'h77A5, 16'h7811, 16'h6622, 16'hFF3C,
      16'h3381, 16'h10FF, 16'hB444, 16'hDD00
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cfg_a = '0, cfg_b = '0;
   logic we_a = 1'b0, we_b = 1'b0;
   logic [IW-1:0] wd_a = '0, wd_b = '0;
   logic rq_a = 1'b0, rq_b = 1'b0;
   logic [2:0] alvl = '0;
   logic as_n = 1'b1, ds_n = 1'b1, ack_n = 1'b1;
   logic [NL-1:0] irq_a, irq_b;
   logic ao_a, ao_b, xa_a, xa_b, oe_a, oe_b;
   logic [IW-1:0] vd_a, vd_b;
   logic [NL-1:0] irq_bus;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign irq_bus = irq_a & irq_b;

   irqc_daisy_interrupter #(.NUM_LINES(NL), .ID_W(IW), .SYNC_STAGES(SS)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_cfg(cfg_a), .sid_we(we_a), .sid_wdata(wd_a),
      .src_req(rq_a), .irq_line_n(irq_a), .addr_lvl(alvl), .strobe_as_n(as_n),
      .strobe_ds_n(ds_n), .ack_chain_in_n(ack_n), .ack_chain_out_n(ao_a),
      .xfer_ack_n(xa_a), .vec_data(vd_a), .vec_oe(oe_a)
   );

   irqc_daisy_interrupter #(.NUM_LINES(NL), .ID_W(IW), .SYNC_STAGES(SS)) dut2_i (
      .clk(clk), .rst_n(rst_n), .line_cfg(cfg_b), .sid_we(we_b), .sid_wdata(wd_b),
      .src_req(rq_b), .irq_line_n(irq_b), .addr_lvl(alvl), .strobe_as_n(as_n),
      .strobe_ds_n(ds_n), .ack_chain_in_n(ao_a), .ack_chain_out_n(ao_b),
      .xfer_ack_n(xa_b), .vec_data(vd_b), .vec_oe(oe_b)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] ca, input logic [2:0] cb);
      @(negedge clk);
      rst_n = 1'b0; cfg_a = ca; cfg_b = cb;
      as_n = 1'b1; ds_n = 1'b1; ack_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_a(input logic [IW-1:0] v);
      we_a = 1'b1; wd_a = v; @(negedge clk); we_a = 1'b0;
   endtask

   task automatic load_b(input logic [IW-1:0] v);
      we_b = 1'b1; wd_b = v; @(negedge clk); we_b = 1'b0;
   endtask

   task automatic pulse_a;
      rq_a = 1'b1; @(negedge clk); rq_a = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_b;
      rq_b = 1'b1; @(negedge clk); rq_b = 1'b0; @(negedge clk);
   endtask

   // opens an acknowledge cycle and waits until either block reacts
   task automatic open_ack(input logic [2:0] lvl);
      alvl = lvl; as_n = 1'b0; ds_n = 1'b0; ack_n = 1'b0;
      for (int i = 0; i < WAITMAX; i++) begin
         @(negedge clk);
         if (!xa_a || !ao_a) break;
      end
      // downstream needs its own synchroniser delay
      for (int i = 0; i < WAITMAX; i++) begin
         if (!xa_a || !xa_b || !ao_b) break;
         @(negedge clk);
      end
   endtask

   task automatic close_ack;
      as_n = 1'b1; ds_n = 1'b1; ack_n = 1'b1;
      for (int i = 0; i < 2 * WAITMAX; i++) begin
         @(negedge clk);
         if (xa_a && ao_a && xa_b && ao_b) break;
      end
      chk("R6", "xfer_ack released", {31'd0, xa_a}, 32'd1);
      chk("R6", "data enable released", {31'd0, oe_a}, 32'd0);
      chk("R5", "chain out released", {31'd0, ao_a}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [NL-1:0] exp_irq;

      // R1: reset state
      do_reset(3'd0, 3'd0);
      chk("R1", "irq lines", {25'd0, irq_a}, 32'h7F);
      chk("R1", "chain out", {31'd0, ao_a}, 32'd1);
      chk("R1", "xfer ack", {31'd0, xa_a}, 32'd1);
      chk("R1", "data enable", {31'd0, oe_a}, 32'd0);
      chk("R1", "data value", {24'd0, vd_a}, 32'd0);

      // table-driven patterns, downstream block disabled
      for (int v = 0; v < 8; v++) begin
         logic [2:0] c, l;
         logic r, s;
         logic [7:0] b;
         {c, r, l, s, b} = VEC[v];
         do_reset(c, 3'd0);
         load_a(b);
         chk("R1", "chain out idle before cycle", {31'd0, ao_a}, 32'd1);
         if (r) pulse_a();
         exp_irq = (r && c != 0) ? ~(NL'(1) << (c - 1)) : '1;
         chk("R2", "irq line select", {25'd0, irq_a}, {25'd0, exp_irq});
         open_ack(l);
         if (s) begin
            chk("R3", "xfer ack asserted", {31'd0, xa_a}, 32'd0);
            chk("R3", "data enable", {31'd0, oe_a}, 32'd1);
            chk("R9", "status byte", {24'd0, vd_a}, {24'd0, b});
            chk("R3", "irq released", {25'd0, irq_a}, 32'h7F);
            chk("R4", "no pass when served", {31'd0, ao_a}, 32'd1);
         end else begin
            chk("R4", "chain out asserted", {31'd0, ao_a}, 32'd0);
            chk("R4", "xfer ack idle", {31'd0, xa_a}, 32'd1);
            chk("R4", "data enable idle", {31'd0, oe_a}, 32'd0);
            chk("R4", "still pending", {25'd0, irq_a}, {25'd0, exp_irq});
         end
         close_ack();
      end

      // R6: strobes held, data strobe low keeps the acknowledge
      do_reset(3'd4, 3'd0);
      load_a(8'h5E);
      pulse_a();
      open_ack(3'd4);
      ack_n = 1'b1; as_n = 1'b1;
      repeat (WAITMAX) @(negedge clk);
      chk("R6", "held while data strobe low", {31'd0, xa_a}, 32'd0);
      close_ack();

      // R7: second cycle after delivery passes on
      open_ack(3'd4);
      chk("R7", "second cycle passes", {31'd0, ao_a}, 32'd0);
      chk("R7", "second cycle no ack", {31'd0, xa_a}, 32'd1);
      close_ack();

      // R9: a later write replaces an earlier one
      do_reset(3'd2, 3'd0);
      load_a(8'h5A);
      load_a(8'h66);
      pulse_a();
      open_ack(3'd2);
      chk("R9", "latest byte", {24'd0, vd_a}, 32'h66);
      close_ack();

      // R8: two blocks on level 5, upstream first
      do_reset(3'd5, 3'd5);
      load_a(8'hA1);
      load_b(8'hB2);
      pulse_a();
      pulse_b();
      chk("R8", "shared line low", {25'd0, irq_bus}, 32'h6F);
      open_ack(3'd5);
      chk("R8", "upstream serves", {24'd0, vd_a}, 32'hA1);
      chk("R8", "downstream idle", {31'd0, xa_b}, 32'd1);
      chk("R8", "downstream sees no token", {31'd0, ao_a}, 32'd1);
      chk("R8", "downstream keeps line", {25'd0, irq_bus}, 32'h6F);
      close_ack();
      open_ack(3'd5);
      chk("R8", "upstream passes", {31'd0, ao_a}, 32'd0);
      chk("R8", "downstream serves", {31'd0, xa_b}, 32'd0);
      chk("R8", "downstream byte", {24'd0, vd_b}, 32'hB2);
      chk("R8", "line released", {25'd0, irq_bus}, 32'h7F);
      close_ack();
      chk("R5", "downstream out released", {31'd0, ao_b}, 32'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule